// File: doc/BRIEF.md
# Sliding-Window Convolution Data Loader

This block supplies complete convolution windows to a downstream multiply-accumulate stage. It reads samples from a synchronous source memory with a one-cycle read latency and stores them in a small circular queue. It presents each window on a wide parallel output with a valid/ready handshake. Neighbouring windows overlap, so after the first window only the samples that are new are fetched. In one-dimensional mode that is one sample per window. In two-dimensional mode it is one column of k values per window.

A pass starts with a single-cycle `start`. On that edge the block latches the mode, the kernel size, the vector or row length N, the base address and the row stride. In one-dimensional mode, sample i is read from `base + i`. In two-dimensional mode, the block walks one strip of k rows, and element (row r, column c) is read from `base + r*stride + c`. The queue has a read start pointer and a write start pointer. Both sit at entry 0 when a pass begins. New data always lands on the entries that the consumer has just released. Each window is emitted oldest entry first, starting at the read pointer.

Top module: `swl_loader`

## Requirements
- R1: After reset, `win_valid`, `done`, `busy` and `mem_rd_en` are low and `win_data` is all zero.
- R2: In 1-D mode (`mode_2d`=0), `ksel`=0 selects k=3 and `ksel`=1 selects k=5. After `start`, k reads are issued at `base_addr`, `base_addr`+1, and so on up to `base_addr`+k-1. The first window has sample j in `win_data[j*DW +: DW]`, and every element at index k or above is zero. `win_valid` rises k+3 clock edges after the edge that sampled `start`.
- R3: In 1-D mode, each accepted window is followed by exactly one read, of the next sample in address order. Window w holds samples w through w+k-1. It becomes valid 4 edges after the accepting edge.
- R4: In 2-D mode (`mode_2d`=1), the first window costs k*k reads in column-major order: column c = 0..k-1 on the outside, row r = 0..k-1 on the inside, at address `base_addr + r*row_stride + c`. Element c*k+r of the window holds X[r][c], and elements from k*k upward are zero. `win_valid` rises k*k+3 edges after the start edge.
- R5: In 2-D mode, each accepted window is followed by exactly k reads, which fetch the next column from row 0 to row k-1. Window w has X[r][w+c] at element c*k+r. It becomes valid k+3 edges after the accepting edge.
- R6: A full pass issues N reads in 1-D mode and k*N reads in 2-D mode. Reads are issued only while the block is fetching.
- R7: While `win_valid` is high and `win_ready` is low, `win_valid` stays high, `win_data` is stable, no read is issued and no queue entry is written.
- R8: The pass ends after N-k+1 accepted windows. `done` is high for exactly one cycle, the cycle after the final accepting edge. In that same cycle `busy` and `win_valid` are low.
- R9: A `start` pulse while `busy` is high is ignored. The pending window and all later windows and reads follow the configuration latched at the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass; sampled only when idle |
| mode_2d | input | 1 | 0: 1-D vector, 1: 2-D column strip |
| ksel | input | 1 | Kernel size select, 0: k=3, 1: k=5 |
| n_len | input | NW | Vector length or row length N (k to NMAX) |
| base_addr | input | AW | Address of the first sample |
| row_stride | input | AW | Address distance between rows in 2-D mode |
| mem_rd_en | output | 1 | Source memory read strobe |
| mem_rd_addr | output | AW | Source memory read address |
| mem_rd_data | input | DW | Read data, valid the cycle after the strobe |
| win_valid | output | 1 | A complete window is presented |
| win_ready | input | 1 | Consumer accepts the window |
| win_data | output | KMAX*KMAX*DW | Window elements, element j at bits j*DW upward |
| done | output | 1 | One-cycle pulse after the last window of a pass |
| busy | output | 1 | A pass is in progress |

## Verification
The first window of a pass is due exactly depth+3 edges after the edge that sampled `start`. Here depth is k in 1-D mode and k*k in 2-D mode. Each later window is due step+3 edges after its accepting edge, with step 1 in 1-D mode and k in 2-D mode. `done` is due one cycle after the last accepting edge. The bench counts edges from each of these events and compares the count with the figure for the current mode and kernel. It reads outputs 1 ns after the edge. It also logs every read address in order. At each window it compares the number of reads issued so far with the exact number that window is owed.

// File: rtl/swl_pkg.sv
`timescale 1ns/1ps
package swl_pkg;

  // Width of small counters, pointers and queue indices.
  localparam int IW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_SHOW
  } swl_state_e;

  // Modular add for operands already below the modulus.
  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] a,
                                             input logic [IW-1:0] b,
                                             input logic [IW-1:0] m);
    logic [IW-1:0] s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

endpackage

// File: rtl/swl_addr_gen.sv
`timescale 1ns/1ps
module swl_addr_gen #(
  parameter int AW = 10,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          mode_2d,
  input  logic [IW-1:0] k,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  logic [IW-1:0] col_q;
  logic [IW-1:0] row_q;
  logic [AW-1:0] roff_q;
  logic [IW-1:0] km1;
  logic          col_end;

  assign km1     = k - IW'(1);
  assign col_end = !mode_2d || (row_q == km1);

  // In 2-D mode the row index moves fastest, which gives column-major order.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      col_q  <= '0;
      row_q  <= '0;
      roff_q <= '0;
    end else if (adv) begin
      if (col_end) begin
        row_q  <= '0;
        roff_q <= '0;
        col_q  <= col_q + IW'(1);
      end else begin
        row_q  <= row_q + IW'(1);
        roff_q <= roff_q + stride;
      end
    end
  end

  assign addr = base + roff_q + AW'(col_q);

  AST_ADDR_1D_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !mode_2d && !clr) |=> (addr == $past(addr) + AW'(1))) else $error("1-D address step"); // R3
  AST_ADDR_2D_ROW: assert property (@(posedge clk) disable iff (rst)
    (adv && mode_2d && !col_end) |=> (addr == $past(addr) + stride)) else $error("2-D row step"); // R4

endmodule

// File: rtl/swl_queue.sv
`timescale 1ns/1ps
module swl_queue #(
  parameter int DW   = 16,
  parameter int KMAX = 5,
  parameter int IW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic [IW-1:0]             depth,
  input  logic [IW-1:0]             step,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_off,
  input  logic [DW-1:0]             wdata,
  input  logic                      ptr_adv,
  input  logic                      cap,
  output logic [KMAX*KMAX*DW-1:0]   win_q
);

  localparam int QMAX = KMAX * KMAX;
  localparam int QIW  = $clog2(QMAX);

  logic [DW-1:0]  mem_q [QMAX];
  logic [IW-1:0]  rd_start_q;
  logic [IW-1:0]  wr_start_q;
  logic [IW-1:0]  wr_idx;
  logic [DW-1:0]  rot [QMAX];

  assign wr_idx = swl_pkg::wrap_add(wr_start_q, wr_off, depth);

  // Storage has no reset and a single write port.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[QIW'(wr_idx)] <= wdata;
  end

  // Both start pointers move together, by one sample or by one column.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_start_q <= '0;
      wr_start_q <= '0;
    end else if (ptr_adv) begin
      rd_start_q <= swl_pkg::wrap_add(rd_start_q, step, depth);
      wr_start_q <= swl_pkg::wrap_add(wr_start_q, step, depth);
    end
  end

  // Rotate so that the entry at the read start pointer lands in element 0.
  for (genvar j = 0; j < QMAX; j++) begin : g_rot
    logic [IW-1:0] idx;
    assign idx    = swl_pkg::wrap_add(rd_start_q, IW'(j), depth);
    assign rot[j] = (IW'(j) < depth) ? mem_q[QIW'(idx)] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (cap) begin
      for (int j = 0; j < QMAX; j++) win_q[j*DW +: DW] <= rot[j];
    end
  end

  AST_WR_IN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < depth)) else $error("queue write outside depth"); // R4
  AST_CAP_AFTER_WRITES: assert property (@(posedge clk) disable iff (rst)
    cap |-> !wr_en) else $error("capture during write"); // R7

endmodule

// File: rtl/swl_ctrl.sv
`timescale 1ns/1ps
module swl_ctrl
  import swl_pkg::*;
#(
  parameter int AW   = 10,
  parameter int NW   = 6,
  parameter int IW   = 8,
  parameter int K_LO = 3,
  parameter int K_HI = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_2d_i,
  input  logic          ksel_i,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [AW-1:0] ag_addr,
  output logic          mode_o,
  output logic [IW-1:0] k_o,
  output logic [IW-1:0] depth_o,
  output logic [IW-1:0] step_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] stride_o,
  output logic          ag_clr,
  output logic          ag_adv,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          q_wr_en,
  output logic [IW-1:0] q_wr_off,
  output logic          ptr_adv,
  output logic          cap,
  output logic          win_valid,
  input  logic          win_ready,
  output logic          done,
  output logic          busy
);

  swl_state_e    st_q;
  logic          mode_q;
  logic [IW-1:0] k_q, n_q, need_q, iss_q, ret_q, wcnt_q;
  logic          rd_en_q, ret_v_q, step_round_q, done_q;
  logic [AW-1:0] addr_q, base_q, stride_q;
  logic [IW-1:0] k_in, total;
  logic          issue, last_ret, hs;

  assign k_in     = ksel_i ? IW'(K_HI) : IW'(K_LO);
  assign depth_o  = mode_q ? (k_q * k_q) : k_q;
  assign step_o   = mode_q ? k_q : IW'(1);
  assign total    = n_q - k_q + IW'(1);
  assign issue    = (st_q == ST_FETCH) && (iss_q != need_q);
  assign last_ret = ret_v_q && (ret_q == need_q - IW'(1));
  assign hs       = (st_q == ST_SHOW) && win_ready;

  assign mode_o      = mode_q;
  assign k_o         = k_q;
  assign base_o      = base_q;
  assign stride_o    = stride_q;
  assign ag_clr      = (st_q == ST_IDLE) && start;
  assign ag_adv      = issue;
  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = addr_q;
  assign q_wr_en     = ret_v_q;
  assign q_wr_off    = ret_q;
  assign ptr_adv     = last_ret && step_round_q;
  assign cap         = (st_q == ST_CAPT);
  assign win_valid   = (st_q == ST_SHOW);
  assign done        = done_q;
  assign busy        = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      mode_q       <= 1'b0;
      k_q          <= IW'(K_LO);
      n_q          <= IW'(K_LO);
      need_q       <= '0;
      iss_q        <= '0;
      ret_q        <= '0;
      wcnt_q       <= '0;
      rd_en_q      <= 1'b0;
      ret_v_q      <= 1'b0;
      step_round_q <= 1'b0;
      done_q       <= 1'b0;
      addr_q       <= '0;
      base_q       <= '0;
      stride_q     <= '0;
    end else begin
      // Read pipeline: the strobe is registered, and data returns one cycle later.
      rd_en_q <= issue;
      ret_v_q <= rd_en_q;
      done_q  <= 1'b0;
      if (issue) begin
        addr_q <= ag_addr;
        iss_q  <= iss_q + IW'(1);
      end
      if (ret_v_q) ret_q <= ret_q + IW'(1);
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            mode_q       <= mode_2d_i;
            k_q          <= k_in;
            n_q          <= IW'(n_i);
            base_q       <= base_i;
            stride_q     <= stride_i;
            need_q       <= mode_2d_i ? (k_in * k_in) : k_in;
            iss_q        <= '0;
            ret_q        <= '0;
            wcnt_q       <= '0;
            step_round_q <= 1'b0;
            st_q         <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (last_ret) st_q <= ST_CAPT;
        end
        ST_CAPT: st_q <= ST_SHOW;
        ST_SHOW: begin
          if (win_ready) begin
            wcnt_q <= wcnt_q + IW'(1);
            if (wcnt_q == total - IW'(1)) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              need_q       <= step_o;
              iss_q        <= '0;
              ret_q        <= '0;
              step_round_q <= 1'b1;
              st_q         <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(hs)) else $error("done without acceptance"); // R8
  AST_NO_FETCH_WHILE_VALID: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !mem_rd_en) else $error("read while window pending"); // R7
  AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (st_q == ST_FETCH)) else $error("read outside fetch"); // R6

endmodule

// File: rtl/swl_loader.sv
`timescale 1ns/1ps
module swl_loader #(
  parameter int DW   = 16,
  parameter int AW   = 10,
  parameter int KMAX = 5,
  parameter int KMIN = 3,
  parameter int NMAX = 32,
  localparam int NW  = $clog2(NMAX + 1),
  localparam int WW  = KMAX * KMAX * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_2d,
  input  logic          ksel,
  input  logic [NW-1:0] n_len,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] row_stride,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          win_valid,
  input  logic          win_ready,
  output logic [WW-1:0] win_data,
  output logic          done,
  output logic          busy
);

  localparam int IW = swl_pkg::IW;

  logic          mode_q;
  logic [IW-1:0] k_q, depth, step, wr_off;
  logic [AW-1:0] base_q, stride_q, ag_addr;
  logic          ag_clr, ag_adv, wr_en, ptr_adv, cap;

  swl_ctrl #(
    .AW(AW), .NW(NW), .IW(IW), .K_LO(KMIN), .K_HI(KMAX)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .mode_2d_i(mode_2d), .ksel_i(ksel), .n_i(n_len),
    .base_i(base_addr), .stride_i(row_stride), .ag_addr(ag_addr),
    .mode_o(mode_q), .k_o(k_q), .depth_o(depth), .step_o(step),
    .base_o(base_q), .stride_o(stride_q),
    .ag_clr(ag_clr), .ag_adv(ag_adv),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .q_wr_en(wr_en), .q_wr_off(wr_off), .ptr_adv(ptr_adv), .cap(cap),
    .win_valid(win_valid), .win_ready(win_ready), .done(done), .busy(busy)
  );

  swl_addr_gen #(.AW(AW), .IW(IW)) agen_i (
    .clk(clk), .rst(rst), .clr(ag_clr), .mode_2d(mode_q), .k(k_q),
    .base(base_q), .stride(stride_q), .adv(ag_adv), .addr(ag_addr)
  );

  swl_queue #(.DW(DW), .KMAX(KMAX), .IW(IW)) queue_i (
    .clk(clk), .rst(rst), .clr(ag_clr), .depth(depth), .step(step),
    .wr_en(wr_en), .wr_off(wr_off), .wdata(mem_rd_data),
    .ptr_adv(ptr_adv), .cap(cap), .win_q(win_data)
  );

  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !win_ready) |=> (win_valid && $stable(win_data))) else $error("window not held"); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !wr_en) else $error("queue written while window pending"); // R7

endmodule

// File: tb/swl_loader_tb.sv
`timescale 1ns/1ps
module swl_loader_tb_top;

  localparam int DW   = 16;
  localparam int AW   = 10;
  localparam int KMAX = 5;
  localparam int NMAX = 32;
  localparam int NW   = $clog2(NMAX + 1);
  localparam int QMAX = KMAX * KMAX;
  localparam int WW   = QMAX * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode_2d = 1'b0;
  logic          ksel = 1'b0;
  logic [NW-1:0] n_len = '0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] row_stride = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          win_valid;
  logic          win_ready = 1'b0;
  logic [WW-1:0] win_data;
  logic          done;
  logic          busy;

  int checks = 0;
  int failures = 0;
  int rd_n = 0;
  int rd_log [1024];

  always #5 clk = ~clk;

  swl_loader #(.DW(DW), .AW(AW), .KMAX(KMAX), .NMAX(NMAX)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_2d(mode_2d), .ksel(ksel),
    .n_len(n_len), .base_addr(base_addr), .row_stride(row_stride),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .win_valid(win_valid), .win_ready(win_ready), .win_data(win_data),
    .done(done), .busy(busy)
  );

  function automatic logic [DW-1:0] sample_at(input int a);
    return DW'((a * 37 + 11) & 16'hFFFF);
  endfunction

  // Source memory model: one-cycle read latency, with every read address logged.
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= sample_at(int'(mem_rd_addr));
      rd_log[rd_n % 1024] <= int'(mem_rd_addr);
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one pass and checks latency, contents, read counts, read order and done.
  task automatic run_pass(input bit m2, input bit ks, input int n, input int base,
                          input int stride, input int stall_at, input int ign_at,
                          input string rq_fill, input string rq_step);
    int k, depth, step, total, r0, lat, exp_lat, err_j, nreads;
    longint ea, aa;
    logic [WW-1:0] snap;
    int rs;
    k = ks ? 5 : 3;
    depth = m2 ? k * k : k;
    step = m2 ? k : 1;
    total = n - k + 1;
    r0 = rd_n;
    @(negedge clk);
    mode_2d = m2; ksel = ks; n_len = NW'(n);
    base_addr = AW'(base); row_stride = AW'(stride); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < total; w++) begin
      lat = 0;
      while (!win_valid && lat < 400) begin
        @(posedge clk); #1; lat++;
      end
      exp_lat = (w == 0) ? depth + 3 : step + 3;
      chk(lat == exp_lat, (w == 0) ? rq_fill : rq_step, "window latency", lat, exp_lat);
      err_j = -1; ea = 0; aa = 0;
      for (int j = 0; j < QMAX; j++) begin
        logic [DW-1:0] e;
        if (j >= depth) e = '0;
        else if (m2) e = sample_at(base + (j % k) * stride + w + j / k);
        else e = sample_at(base + w + j);
        if (win_data[j*DW +: DW] !== e && err_j < 0) begin
          err_j = j; ea = e; aa = win_data[j*DW +: DW];
        end
      end
      chk(err_j < 0, (w == 0) ? rq_fill : rq_step, "window contents", aa, ea);
      chk(rd_n - r0 == depth + w * step, (w == 0) ? rq_fill : rq_step,
          "reads so far", rd_n - r0, depth + w * step);
      if (w == stall_at) begin
        snap = win_data; rs = rd_n;
        for (int c = 0; c < 4; c++) begin
          @(posedge clk); #1;
          chk(win_valid && win_data == snap && rd_n == rs, "R7", "held window reads",
              rd_n, rs);
        end
      end
      if (w == ign_at) begin
        snap = win_data;
        @(negedge clk);
        start = 1'b1; mode_2d = ~m2; ksel = ~ks; base_addr = AW'(base + 100);
        @(negedge clk);
        start = 1'b0; mode_2d = m2; ksel = ks; base_addr = AW'(base);
        chk(win_valid && busy && win_data == snap, "R9", "window after ignored start",
            win_valid, 1);
      end
      @(negedge clk);
      win_ready = 1'b1;
      @(posedge clk); #1;
      win_ready = 1'b0;
      if (w == total - 1)
        chk(done && !busy && !win_valid, "R8", "done after last window", done, 1);
      else
        chk(!done && busy, "R8", "done before last window", done, 0);
    end
    @(posedge clk); #1;
    chk(!done, "R8", "done width", done, 0);
    nreads = m2 ? k * n : n;
    chk(rd_n - r0 == nreads, "R6", "total reads", rd_n - r0, nreads);
    err_j = -1; ea = 0; aa = 0;
    for (int i = 0; i < nreads; i++) begin
      int e;
      e = m2 ? base + (i % k) * stride + i / k : base + i;
      if (rd_log[(r0 + i) % 1024] != e && err_j < 0) begin
        err_j = i; ea = e; aa = rd_log[(r0 + i) % 1024];
      end
    end
    chk(err_j < 0, rq_fill, "read address order", aa, ea);
  endtask

  task automatic test_reset();
    chk(!win_valid && !done && !busy && !mem_rd_en, "R1", "control outputs after reset",
        {win_valid, done, busy, mem_rd_en}, 0);
    chk(win_data == '0, "R1", "window data after reset", (win_data != '0), 0);
  endtask

  task automatic test_1d_k3();
    run_pass(1'b0, 1'b0, 10, 16, 0, 2, -1, "R2", "R3");
  endtask

  task automatic test_1d_k5_ignore_start();
    run_pass(1'b0, 1'b1, 12, 200, 0, -1, 1, "R2", "R3");
  endtask

  task automatic test_2d_k3();
    run_pass(1'b1, 1'b0, 8, 40, 32, 3, -1, "R4", "R5");
  endtask

  task automatic test_2d_k5();
    run_pass(1'b1, 1'b1, 7, 300, 20, -1, 2, "R4", "R5");
  endtask

  task automatic test_single_window();
    run_pass(1'b0, 1'b1, 5, 500, 0, 0, -1, "R2", "R3");
    run_pass(1'b1, 1'b0, 3, 600, 8, -1, -1, "R4", "R5");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_1d_k3();
    test_1d_k5_ignore_start();
    test_2d_k3();
    test_2d_k5();
    test_single_window();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule